// File: doc/BRIEF.md
# Credit-Gated Round-Robin Link Scheduler

This block drives one output link of a buffered crosspoint switch module. Several upstream source FIFOs present only their head-of-line cell. Each head cell names one of a set of downstream destination queues. Those destination queues share a single input-line buffer on the far side of the link. In every time slot the scheduler grants at most one source, and the grant is combinational from the current heads. The source FIFO pops its head on the same clock edge.

Each destination queue has two counters. The outstanding count is the scheduler's estimate of the queue's fill. The in-flight count holds the cells sent toward that queue since its last credit. One shared count estimates the fill of the whole line buffer. A head cell may be sent only when both its queue's count and the shared count are below their limits. When a credit arrives, the scheduler does not add the freed slots to the count. It rebuilds the queue's count from the occupancy reported downstream plus its own in-flight cells. The shared count is then rebuilt as the sum of all per-queue counts. Downstream queues are expected to send credits on a fixed period of 8 slots, one queue per cycle. The block accepts a credit in any cycle.

Top module: `xcs_link_sched`

## Requirements
- R1: After a synchronous active-low reset, all counters are zero and the round-robin pointer sits at source 0. With no valid head, `gnt_vld_o` is 0 and `gnt_src_o` is all zeros.
- R2: A grant in a cycle without a credit raises the chosen queue's outstanding count by one, its in-flight count by one, and the shared count by one.
- R3: A head cell whose destination queue has an outstanding count of `Q_SIZE` (default 15) or more is not eligible.
- R4: No head cell is eligible while the shared count is `BUF_SIZE` (default 64) or more.
- R5: A credit for queue d carrying occupancy v sets d's outstanding count to v plus its in-flight count, plus one if d is granted in that same cycle. The in-flight count becomes 1 if d is granted in that cycle and 0 otherwise. Eligibility in the credit cycle uses the counts from before the credit.
- R6: In a cycle with a valid credit, the shared count becomes the sum of all per-queue outstanding counts after that cycle's update. A credit whose queue index is `N_DQ` or more is ignored.
- R7: Among eligible sources, the one granted is the first met when scanning upward from the pointer with wrap-around. Bit s of the one-hot `gnt_src_o` marks source s, and `gnt_dq_o` repeats that source's head index.
- R8: After a grant to source s, the pointer moves to s+1, wrapping to 0. In a cycle with no grant, the pointer does not move.
- R9: Only the head cell of each source is considered. A blocked head holds back all cells behind it, even when their queues have room.
- R10: Source s's head destination index sits in bits [s*DQW +: DQW] of `hol_dq_i`. A head whose index is `N_DQ` or more is never eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hol_vld_i | input | N_SRC | Source s holds a head cell |
| hol_dq_i | input | N_SRC*DQW | Head destination index per source, source s at [s*DQW +: DQW] |
| crd_vld_i | input | 1 | Credit message present this cycle |
| crd_dq_i | input | DQW | Destination queue the credit reports on |
| crd_occ_i | input | CW | Cells still held in that queue |
| gnt_vld_o | output | 1 | A cell is sent this slot |
| gnt_src_o | output | N_SRC | One-hot granted source; its FIFO pops |
| gnt_dq_o | output | DQW | Destination queue of the sent cell |

## Verification
The grant and its destination index are combinational. They are due in the same cycle the head inputs and the current counter state are present. Counter and pointer effects of a grant or a credit become visible one edge later, as a changed grant pattern in the next slot. The bench drives inputs on the falling edge and samples the outputs 1 ns later. It compares them against a reference model of the counters, pointer and FIFOs, and advances that model only after the comparison, which mirrors the single register stage inside the block.

// File: rtl/xcs_pkg.sv
// Shared defaults and helpers for the credit-gated link scheduler.
// Assumes: all users import this package before elaboration of the top.
package xcs_pkg;
    localparam int XCS_DEF_SRC  = 4;
    localparam int XCS_DEF_DQ   = 5;
    localparam int XCS_DEF_QSZ  = 15;
    localparam int XCS_DEF_BUF  = 64;

    // Index width for n items, at least one bit.
    function automatic int xcs_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/xcs_dq_counter.sv
// Per-destination-queue counters: outstanding estimate and cells in flight
// since the last credit. Assumes at most one send and one credit per cycle.
module xcs_dq_counter #(
    parameter int Q_SIZE = 15,
    parameter int CW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          send_i,
    input  logic          crd_i,
    input  logic [CW-1:0] crd_occ_i,
    output logic [CW-1:0] qoc_o,
    output logic [CW-1:0] qoc_nxt_o,
    output logic          room_o
);
    logic [CW-1:0] qoc_q;
    logic [CW-1:0] roc_q;
    logic [CW-1:0] roc_d;
    logic [CW-1:0] inc;

    assign inc = {{(CW-1){1'b0}}, send_i};

    // Next-state rule: a credit rebuilds, otherwise a send increments.
    always_comb begin
        if (crd_i) begin
            qoc_nxt_o = crd_occ_i + roc_q + inc;
            roc_d     = inc;
        end else begin
            qoc_nxt_o = qoc_q + inc;
            roc_d     = roc_q + inc;
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qoc_q <= '0;
            roc_q <= '0;
        end else begin
            qoc_q <= qoc_nxt_o;
            roc_q <= roc_d;
        end
    end

    // Queue has space while its estimate is under the crosspoint limit.
    assign room_o = (qoc_q < CW'(Q_SIZE));
    assign qoc_o  = qoc_q;
endmodule

// File: rtl/xcs_buf_counter.sv
// Shared line-buffer counter: rises per send, rebuilt from the per-queue
// sum whenever a credit is applied. Assumes the sum fits in BW bits.
module xcs_buf_counter #(
    parameter int BUF_SIZE = 64,
    parameter int BW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          send_i,
    input  logic          crd_i,
    input  logic [BW-1:0] sum_i,
    output logic [BW-1:0] boc_o,
    output logic          room_o
);
    logic [BW-1:0] boc_q;

    // Count update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     boc_q <= '0;
        else if (crd_i) boc_q <= sum_i;
        else            boc_q <= boc_q + {{(BW-1){1'b0}}, send_i};
    end

    // Buffer has space while the shared estimate is under its limit.
    assign room_o = (boc_q < BW'(BUF_SIZE));
    assign boc_o  = boc_q;
endmodule

// File: rtl/xcs_rr_arbiter.sv
// Round-robin arbiter: scans requests upward from the pointer with wrap,
// grants the first, and moves the pointer past it. Assumes N >= 1.
module xcs_rr_arbiter #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic [IW-1:0] gnt_idx_o,
    output logic          gnt_any_o,
    output logic [IW-1:0] ptr_o
);
    logic [IW-1:0] ptr_q;

    // Rotating priority scan starting at the pointer.
    always_comb begin
        gnt_o     = '0;
        gnt_idx_o = '0;
        gnt_any_o = 1'b0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = int'(ptr_q) + k;
            if (c >= N) c = c - N;
            if (!gnt_any_o && req_i[c]) begin
                gnt_any_o = 1'b1;
                gnt_o[c]  = 1'b1;
                gnt_idx_o = IW'(c);
            end
        end
    end

    // Pointer moves to the source after the granted one; holds when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (gnt_any_o)
            ptr_q <= (gnt_idx_o == IW'(N-1)) ? '0 : gnt_idx_o + 1'b1;
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/xcs_link_sched.sv
// Top of the credit-gated link scheduler. Decides head-of-line eligibility
// per source, arbitrates one grant per slot, and keeps per-queue and shared
// counters. Assumes the granted FIFO pops on the same edge and credits
// carry the downstream queue occupancy at most once per cycle.
module xcs_link_sched
    import xcs_pkg::*;
#(
    parameter int N_SRC    = XCS_DEF_SRC,
    parameter int N_DQ     = XCS_DEF_DQ,
    parameter int Q_SIZE   = XCS_DEF_QSZ,
    parameter int BUF_SIZE = XCS_DEF_BUF,
    localparam int DQW     = xcs_idx_w(N_DQ),
    localparam int SW      = xcs_idx_w(N_SRC),
    localparam int CW      = $clog2(2*Q_SIZE + 2),
    localparam int BW      = $clog2(N_DQ*(2*Q_SIZE + 1) + BUF_SIZE + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     hol_vld_i,
    input  logic [N_SRC*DQW-1:0] hol_dq_i,
    input  logic                 crd_vld_i,
    input  logic [DQW-1:0]       crd_dq_i,
    input  logic [CW-1:0]        crd_occ_i,
    output logic                 gnt_vld_o,
    output logic [N_SRC-1:0]     gnt_src_o,
    output logic [DQW-1:0]       gnt_dq_o
);
    localparam int PADN = 1 << DQW;

    logic [N_DQ-1:0]    dq_room;
    logic [PADN-1:0]    room_pad;
    logic [N_DQ-1:0]    send_vec;
    logic [N_DQ-1:0]    crd_vec;
    logic [CW-1:0]      qoc_q   [N_DQ];
    logic [CW-1:0]      qoc_nxt [N_DQ];
    logic [N_DQ*CW-1:0] qoc_flat;
    logic [BW-1:0]      qoc_sum;
    logic [BW-1:0]      boc_q;
    logic               buf_room;
    logic [N_SRC-1:0]   elig;
    logic [SW-1:0]      gnt_idx;
    logic               gnt_any;
    logic [SW-1:0]      rr_ptr;

    // Widen queue room to every encodable index; out-of-range reads as full.
    always_comb begin
        room_pad            = '0;
        room_pad[N_DQ-1:0]  = dq_room;
    end

    // Head-of-line eligibility for each source.
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        logic [DQW-1:0] head_dq;
        assign head_dq = hol_dq_i[s*DQW +: DQW];
        assign elig[s] = hol_vld_i[s] & room_pad[head_dq] & buf_room;
    end

    xcs_rr_arbiter #(.N(N_SRC), .IW(SW)) arb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (elig),
        .gnt_o     (gnt_src_o),
        .gnt_idx_o (gnt_idx),
        .gnt_any_o (gnt_any),
        .ptr_o     (rr_ptr)
    );

    // Destination index of the granted head cell.
    always_comb begin
        gnt_dq_o = '0;
        for (int s = 0; s < N_SRC; s++)
            if (gnt_src_o[s]) gnt_dq_o = hol_dq_i[s*DQW +: DQW];
    end

    assign gnt_vld_o = gnt_any;

    // One counter pair per destination queue.
    for (genvar d = 0; d < N_DQ; d++) begin : g_dq
        assign send_vec[d] = gnt_any   && (gnt_dq_o == DQW'(d));
        assign crd_vec[d]  = crd_vld_i && (crd_dq_i == DQW'(d));
        xcs_dq_counter #(.Q_SIZE(Q_SIZE), .CW(CW)) cnt_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .send_i    (send_vec[d]),
            .crd_i     (crd_vec[d]),
            .crd_occ_i (crd_occ_i),
            .qoc_o     (qoc_q[d]),
            .qoc_nxt_o (qoc_nxt[d]),
            .room_o    (dq_room[d])
        );
        assign qoc_flat[d*CW +: CW] = qoc_q[d];
    end

    // Sum of post-update per-queue counts for the shared rebuild.
    always_comb begin
        qoc_sum = '0;
        for (int d = 0; d < N_DQ; d++)
            qoc_sum = qoc_sum + BW'(qoc_nxt[d]);
    end

    xcs_buf_counter #(.BUF_SIZE(BUF_SIZE), .BW(BW)) buf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .send_i (gnt_any),
        .crd_i  (|crd_vec),
        .sum_i  (qoc_sum),
        .boc_o  (boc_q),
        .room_o (buf_room)
    );
endmodule

// File: rtl/xcs_link_sched_chk.sv
// Property checker for the link scheduler, attached by bind.
// Assumes reset is held low across the first clock edge.
module xcs_link_sched_chk #(
    parameter int N_SRC    = 4,
    parameter int N_DQ     = 5,
    parameter int Q_SIZE   = 15,
    parameter int BUF_SIZE = 64,
    parameter int DQW      = 3,
    parameter int SW       = 2,
    parameter int CW       = 5,
    parameter int BW       = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_SRC-1:0]   hol_vld_i,
    input logic               crd_vld_i,
    input logic               gnt_vld_o,
    input logic [N_SRC-1:0]   gnt_src_o,
    input logic [DQW-1:0]     gnt_dq_o,
    input logic [N_DQ*CW-1:0] qoc_flat,
    input logic [BW-1:0]      boc_q,
    input logic [SW-1:0]      rr_ptr
);
    // R7
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o |-> $countones(gnt_src_o) == 1);

    // R1
    gnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_vld_o |-> gnt_src_o == '0);

    // R9
    gnt_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_src_o & ~hol_vld_i) == '0);

    // R10
    gnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o |-> int'(gnt_dq_o) < N_DQ);

    // R3
    q_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld_o && int'(gnt_dq_o) < N_DQ) |->
            qoc_flat[int'(gnt_dq_o)*CW +: CW] < CW'(Q_SIZE));

    // R4
    buf_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o |-> boc_q < BW'(BUF_SIZE));

    // R2
    buf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld_o && !crd_vld_i) |=> boc_q == $past(boc_q) + BW'(1));

    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_vld_o |=> rr_ptr == $past(rr_ptr));
endmodule

bind xcs_link_sched xcs_link_sched_chk #(
    .N_SRC(N_SRC), .N_DQ(N_DQ), .Q_SIZE(Q_SIZE), .BUF_SIZE(BUF_SIZE),
    .DQW(DQW), .SW(SW), .CW(CW), .BW(BW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hol_vld_i (hol_vld_i),
    .crd_vld_i (crd_vld_i),
    .gnt_vld_o (gnt_vld_o),
    .gnt_src_o (gnt_src_o),
    .gnt_dq_o  (gnt_dq_o),
    .qoc_flat  (qoc_flat),
    .boc_q     (boc_q),
    .rr_ptr    (rr_ptr)
);

// File: tb/xcs_link_sched_tb_top.sv
// Bench: reference model of FIFOs, counters and pointer; directed corners
// followed by seeded random traffic with periodic credits.
module xcs_link_sched_tb_top;
    localparam int NS = 4, ND = 5, QS = 15, BS = 64, DQW = 3, CW = 5, FD = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NS-1:0]     hol_vld;
    logic [NS*DQW-1:0] hol_dq;
    logic              crd_vld;
    logic [DQW-1:0]    crd_dq;
    logic [CW-1:0]     crd_occ;
    logic              gnt_vld;
    logic [NS-1:0]     gnt_src;
    logic [DQW-1:0]    gnt_dq;

    always #2 clk = ~clk;

    xcs_link_sched #(.N_SRC(NS), .N_DQ(ND), .Q_SIZE(QS), .BUF_SIZE(BS)) dut_i (
        .clk(clk), .rst_n(rst_n), .hol_vld_i(hol_vld), .hol_dq_i(hol_dq),
        .crd_vld_i(crd_vld), .crd_dq_i(crd_dq), .crd_occ_i(crd_occ),
        .gnt_vld_o(gnt_vld), .gnt_src_o(gnt_src), .gnt_dq_o(gnt_dq));

    int n_chk = 0, n_fail = 0;
    string tag = "R1";
    int fq [NS][FD];
    int fcnt [NS];
    int m_qoc [ND], m_roc [ND], ds_occ [ND];
    int m_boc, m_ptr;
    int c_vld, c_dq, c_occ;
    bit done = 0;

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < NS; s++) fcnt[s] = 0;
        for (int d = 0; d < ND; d++) begin m_qoc[d] = 0; m_roc[d] = 0; ds_occ[d] = 0; end
        m_boc = 0; m_ptr = 0; c_vld = 0; c_dq = 0; c_occ = 0;
    endtask

    task automatic push(int s, int dq, int times);
        for (int i = 0; i < times; i++)
            if (fcnt[s] < FD) begin fq[s][fcnt[s]] = dq; fcnt[s]++; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; hol_vld = '0; hol_dq = '0; crd_vld = 0; crd_dq = '0; crd_occ = '0;
        model_clear();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One slot: drive, sample combinational grant, advance the model.
    task automatic step();
        int exp_s, sd, sum;
        @(negedge clk);
        for (int s = 0; s < NS; s++) begin
            hol_vld[s] = (fcnt[s] > 0);
            hol_dq[s*DQW +: DQW] = (fcnt[s] > 0) ? DQW'(fq[s][0]) : '0;
        end
        crd_vld = c_vld[0]; crd_dq = DQW'(c_dq); crd_occ = CW'(c_occ);
        #1;
        exp_s = -1;
        for (int k = 0; k < NS; k++) begin
            int c;
            c = (m_ptr + k) % NS;
            if (exp_s < 0 && fcnt[c] > 0 && fq[c][0] < ND &&
                m_qoc[fq[c][0]] < QS && m_boc < BS) exp_s = c;
        end
        chk("grant valid", int'(gnt_vld), exp_s >= 0);
        chk("grant source", int'(gnt_src), exp_s >= 0 ? (1 << exp_s) : 0);
        sd = -1;
        if (exp_s >= 0) begin
            sd = fq[exp_s][0];
            chk("grant queue", int'(gnt_dq), sd);
            for (int i = 0; i < FD-1; i++) fq[exp_s][i] = fq[exp_s][i+1];
            fcnt[exp_s]--;
            m_ptr = (exp_s + 1) % NS;
            ds_occ[sd]++;
        end
        for (int d = 0; d < ND; d++) begin
            int hit;
            hit = (sd == d);
            if (c_vld != 0 && c_dq == d) begin
                m_qoc[d] = c_occ + m_roc[d] + hit; m_roc[d] = hit;
            end else begin
                m_qoc[d] += hit; m_roc[d] += hit;
            end
        end
        if (c_vld != 0 && c_dq < ND) begin
            sum = 0;
            for (int d = 0; d < ND; d++) sum += m_qoc[d];
            m_boc = sum;
        end else if (sd >= 0) m_boc++;
        c_vld = 0;
    endtask

    task automatic credit(int dq, int occ);
        c_vld = 1; c_dq = dq; c_occ = occ;
        step();
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        tag = "R1 reset idle";
        repeat (3) step();

        tag = "R2 R3 queue limit";
        push(0, 0, 16);
        repeat (18) step();

        tag = "R5 credit rebuild";
        credit(0, 0);
        repeat (2) step();
        credit(0, 0);
        repeat (3) step();

        do_reset();
        tag = "R9 head blocking";
        push(0, 1, 16); push(0, 2, 1); push(1, 2, 4);
        repeat (30) step();

        do_reset();
        tag = "R4 R6 shared limit";
        push(0, 0, 15); push(0, 4, 10);
        push(1, 1, 15); push(2, 2, 15); push(3, 3, 15);
        repeat (70) step();
        credit(4, 0);
        repeat (2) step();
        credit(0, 0);
        credit(0, 0);
        repeat (10) step();

        do_reset();
        tag = "R10 out of range";
        push(0, 6, 1); push(0, 0, 2); push(1, 1, 3);
        credit(7, 9);
        repeat (8) step();

        do_reset();
        tag = "R7 R8 rotation";
        for (int s = 0; s < NS; s++) push(s, s, 6);
        repeat (26) step();

        do_reset();
        tag = "R2 R5 R6 R7 R8 R9 random";
        void'($urandom(32'd7741));
        for (int cyc = 0; cyc < 5000; cyc++) begin
            for (int s = 0; s < NS; s++)
                if ($urandom % 2 == 0) begin
                    int r;
                    r = $urandom % 16;
                    push(s, (r < 15) ? (r % ND) : (ND + int'($urandom % 3)), 1);
                end
            for (int d = 0; d < ND; d++)
                if (ds_occ[d] > 0 && $urandom % 4 == 0) ds_occ[d]--;
            if (cyc % 8 < ND) begin
                c_vld = 1; c_dq = cyc % 8; c_occ = ds_occ[cyc % 8];
            end else if (cyc % 8 == ND) begin
                c_vld = 1; c_dq = ND + int'($urandom % 3); c_occ = int'($urandom % 16);
            end
            step();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule